// File: doc/BRIEF.md
# Clocked Synchronous Serial Transmitter

This block sends bytes over a clocked synchronous serial link. It has one holding register and one shift register, so a host can load the next byte while the current one is still going out. A host write stores a byte in the holding register and marks it full by clearing the empty flag. The shift logic takes the byte when it is free, sets the empty flag again, and shifts the byte out least significant bit first. Each bit takes one serial clock period.

The serial clock can come from either of two sources. In internal mode the block drives the clock pin itself and produces exactly one low pulse per bit. Each half period lasts `div + 1` system clocks. In external mode the block follows an incoming clock: it passes that clock through a synchroniser and shifts data on the falling edges it detects. In both modes data changes on a falling edge, so a receiver samples it on the rising edge.

The empty flag is tested only once per frame, at the end of the most significant bit. If a byte is waiting at that point, the next frame starts with no idle time. If no byte is waiting, the block raises the end flag, leaves the data pin at the level of the last bit and lets the clock pin rest high. Each flag drives an interrupt request, and each request has its own enable.

Top module: `sync_ser_tx`

## Requirements
- R1: After reset the empty flag and the end flag are 1, the clock pin is high and the data pin is high.
- R2: A host write (`wr_en` high for one cycle) stores `wr_data`. From the next cycle both the empty flag and the end flag read 0.
- R3: When `tx_en` is 1 and the empty flag is 0, the block copies the held byte into the shift register and sets the empty flag back to 1. In internal mode the load happens on the next system clock. In external mode it waits for a detected falling edge of the external clock. In internal mode the clock pin goes low and bit 0 appears on the data pin in the same cycle as the load.
- R4: Bits leave in the order bit 0 first through bit 7 last. The data pin changes only when the clock falls, and it is stable while the clock is high.
- R5: In internal mode a frame has exactly 8 low pulses on the clock pin. Each low phase and each high phase lasts `div + 1` system clocks. For one frame, the time from the first fall to the last rise is 15·(`div + 1`) cycles.
- R6: If the empty flag is 0 at the end of the bit-7 high phase, the next byte is loaded and its bit 0 falls with no gap. For n chained frames, the time from the first fall to the last rise is (16n − 1)·(`div + 1`) cycles.
- R7: If the empty flag is 1 at the end of bit 7, the end flag is set to 1, the clock pin rests high and the data pin keeps the bit-7 level.
- R8: `txi_req` equals the empty flag ANDed with `tie`. `tei_req` equals the end flag ANDed with `teie`.
- R9: In external mode (`ext_mode` = 1), `ext_sck` goes through a synchroniser. Nothing loads until a falling edge of `ext_sck` is seen. Each later falling edge moves to the next bit, and `sck_out` stays high throughout.
- R10: When `tx_en` is 0, any frame in progress is dropped. The data pin and the clock pin go high, the two flags keep their values, and no byte is loaded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_en | input | 1 | Transmit enable; 0 aborts and blocks loading |
| ext_mode | input | 1 | 1 = follow `ext_sck`, 0 = drive the clock internally |
| div | input | DIV_W | Half-period length minus one, in system clocks (internal mode) |
| ext_sck | input | 1 | External serial clock, asynchronous |
| wr_en | input | 1 | Host write strobe for the holding register |
| wr_data | input | DATA_W | Byte to transmit |
| tie | input | 1 | Enable for the data-empty request |
| teie | input | 1 | Enable for the transmit-end request |
| sck_out | output | 1 | Serial clock pin |
| txd | output | 1 | Serial data pin |
| tdre | output | 1 | Empty flag of the holding register |
| tend | output | 1 | Transmit-end flag |
| txi_req | output | 1 | Data-empty interrupt request |
| tei_req | output | 1 | Transmit-end interrupt request |

## Verification
The bench chains frames back to back. A design that checked the empty flag at the wrong point, or that waited one phase too long, would leave a gap, and the measured first-fall-to-last-rise span would come out too long. It also checks the data level once a frame has ended. Because bytes ending in both 0 and 1 are used, a design that returned the pin to high at the end instead of holding bit 7 fails. The abort test drops `tx_en` mid-frame and then writes a byte while the block is disabled; a design that cleared the empty flag, left the clock low, or started sending without the enable shows up at the pins. The external-clock test holds the clock high after a write, so a design that loads without waiting for a falling edge is caught, and it also confirms that the clock pin never moves in that mode.

// File: rtl/ssx_pkg.sv
package ssx_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_LOW  = 2'd1,
      ST_HIGH = 2'd2
   } ssx_state_e;
endpackage

// File: rtl/ssx_ext_sync.sv
module ssx_ext_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sck_in,
   output logic rise,
   output logic fall
);
   logic [STAGES-1:0] chain;
   logic              prev;

   // first stage samples the asynchronous pin
   always_ff @(posedge clk) begin
      if (!rst_n) chain[0] <= 1'b1;
      else        chain[0] <= sck_in;
   end

   // remaining stages of the resynchroniser
   for (genvar g = 1; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk) begin
         if (!rst_n) chain[g] <= 1'b1;
         else        chain[g] <= chain[g-1];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) prev <= 1'b1;
      else        prev <= chain[STAGES-1];
   end

   assign rise =  chain[STAGES-1] & ~prev;
   assign fall = ~chain[STAGES-1] &  prev;
endmodule

// File: rtl/ssx_phase_timer.sv
module ssx_phase_timer #(
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [DIV_W-1:0] div,
   output logic             done
);
   logic [DIV_W-1:0] cnt;

   assign done = run && (cnt >= div);

   // counts system clocks inside one half period of the serial clock
   always_ff @(posedge clk) begin
      if (!rst_n)              cnt <= '0;
      else if (!run || done)   cnt <= '0;
      else                     cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/ssx_flags.sv
module ssx_flags #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              load,
   input  logic              end_set,
   input  logic              tie,
   input  logic              teie,
   output logic [DATA_W-1:0] hold_q,
   output logic              tdre,
   output logic              tend,
   output logic              txi_req,
   output logic              tei_req
);
   // holding register, written by the host only
   always_ff @(posedge clk) begin
      if (!rst_n)     hold_q <= '0;
      else if (wr_en) hold_q <= wr_data;
   end

   // host write has priority over the shifter setting the flags
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tdre <= 1'b1;
         tend <= 1'b1;
      end else if (wr_en) begin
         tdre <= 1'b0;
         tend <= 1'b0;
      end else begin
         if (load)    tdre <= 1'b1;
         if (end_set) tend <= 1'b1;
      end
   end

   assign txi_req = tie  & tdre;
   assign tei_req = teie & tend;

   AST_WR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (!tdre && !tend)); // R2
endmodule

// File: rtl/ssx_shift_fsm.sv
module ssx_shift_fsm
   import ssx_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int CNT_W  = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tx_en,
   input  logic              ext_mode,
   input  logic              tdre,
   input  logic [DATA_W-1:0] hold_q,
   input  logic              tick_done,
   input  logic              ext_rise,
   input  logic              ext_fall,
   output logic              load,
   output logic              end_set,
   output logic              txd,
   output logic              sck_int,
   output logic              running
);
   localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(DATA_W - 1);

   ssx_state_e        state;
   logic [DATA_W-1:0] shreg;
   logic [CNT_W-1:0]  bidx;
   logic              step_rise;
   logic              step_fall;
   logic              start_ok;
   logic              last_bit;

   assign step_rise = ext_mode ? ext_rise : tick_done;
   assign step_fall = ext_mode ? ext_fall : tick_done;
   assign start_ok  = ext_mode ? ext_fall : 1'b1;
   assign last_bit  = (bidx == LAST_IDX);
   assign running   = (state != ST_IDLE);
   assign sck_int   = (state != ST_LOW);

   // load and end decisions; the empty flag is examined only at these points
   always_comb begin
      load    = 1'b0;
      end_set = 1'b0;
      case (state)
         ST_IDLE: load = tx_en && !tdre && start_ok;
         ST_HIGH: begin
            if (tx_en && step_fall && last_bit) begin
               load    = !tdre;
               end_set =  tdre;
            end
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state <= ST_IDLE;
         shreg <= '0;
         bidx  <= '0;
         txd   <= 1'b1;
      end else if (!tx_en) begin
         state <= ST_IDLE;
         bidx  <= '0;
         txd   <= 1'b1;
      end else begin
         case (state)
            ST_IDLE: begin
               if (load) begin
                  shreg <= hold_q;
                  txd   <= hold_q[0];
                  bidx  <= '0;
                  state <= ST_LOW;
               end
            end
            ST_LOW: begin
               if (step_rise) state <= ST_HIGH;
            end
            ST_HIGH: begin
               if (step_fall) begin
                  if (!last_bit) begin
                     shreg <= shreg >> 1;
                     txd   <= shreg[1];
                     bidx  <= bidx + 1'b1;
                     state <= ST_LOW;
                  end else if (load) begin
                     shreg <= hold_q;
                     txd   <= hold_q[0];
                     bidx  <= '0;
                     state <= ST_LOW;
                  end else begin
                     state <= ST_IDLE;
                  end
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !tx_en |=> (state == ST_IDLE && txd)); // R10
endmodule

// File: rtl/sync_ser_tx.sv
module sync_ser_tx #(
   parameter int DATA_W      = 8,
   parameter int DIV_W       = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tx_en,
   input  logic              ext_mode,
   input  logic [DIV_W-1:0]  div,
   input  logic              ext_sck,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              tie,
   input  logic              teie,
   output logic              sck_out,
   output logic              txd,
   output logic              tdre,
   output logic              tend,
   output logic              txi_req,
   output logic              tei_req
);
   localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;

   if (DATA_W < 2) begin : g_bad_width
      $error("sync_ser_tx: DATA_W must be at least 2");
   end
   if (DIV_W < 1) begin : g_bad_div
      $error("sync_ser_tx: DIV_W must be at least 1");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("sync_ser_tx: SYNC_STAGES must be at least 2");
   end

   logic [DATA_W-1:0] hold_q;
   logic              load;
   logic              end_set;
   logic              tick_done;
   logic              ext_rise;
   logic              ext_fall;
   logic              sck_int;
   logic              running;

   ssx_ext_sync #(.STAGES(SYNC_STAGES)) i_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .sck_in(ext_sck),
      .rise  (ext_rise),
      .fall  (ext_fall)
   );

   ssx_phase_timer #(.DIV_W(DIV_W)) i_timer (
      .clk  (clk),
      .rst_n(rst_n),
      .run  (running && !ext_mode),
      .div  (div),
      .done (tick_done)
   );

   ssx_flags #(.DATA_W(DATA_W)) i_flags (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (wr_en),
      .wr_data(wr_data),
      .load   (load),
      .end_set(end_set),
      .tie    (tie),
      .teie   (teie),
      .hold_q (hold_q),
      .tdre   (tdre),
      .tend   (tend),
      .txi_req(txi_req),
      .tei_req(tei_req)
   );

   ssx_shift_fsm #(.DATA_W(DATA_W), .CNT_W(CNT_W)) i_fsm (
      .clk      (clk),
      .rst_n    (rst_n),
      .tx_en    (tx_en),
      .ext_mode (ext_mode),
      .tdre     (tdre),
      .hold_q   (hold_q),
      .tick_done(tick_done),
      .ext_rise (ext_rise),
      .ext_fall (ext_fall),
      .load     (load),
      .end_set  (end_set),
      .txd      (txd),
      .sck_int  (sck_int),
      .running  (running)
   );

   // the pin is an input in external mode; keep the driven level high
   assign sck_out = ext_mode ? 1'b1 : sck_int;

   AST_LOAD_SETS_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      (load && !wr_en) |=> tdre); // R3
   AST_TXD_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
      (!ext_mode && $past(!ext_mode) && tx_en && $past(tx_en) &&
       sck_out && $past(sck_out)) |-> $stable(txd)); // R4
   AST_END_SCK_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      end_set |=> sck_out); // R7
   AST_TEND_NEEDS_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tend) |-> $past(tdre)); // R7
endmodule

// File: tb/test_sync_ser_tx.sv
module test_sync_ser_tx;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tx_en = 1'b0;
   logic       ext_mode = 1'b0;
   logic [7:0] div = 8'd0;
   logic       ext_sck = 1'b1;
   logic       wr_en = 1'b0;
   logic [7:0] wr_data = 8'd0;
   logic       tie = 1'b0;
   logic       teie = 1'b0;
   logic       sck_out, txd, tdre, tend, txi_req, tei_req;

   always #5 clk = ~clk;

   sync_ser_tx i_sync_ser_tx (
      .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .ext_mode(ext_mode), .div(div),
      .ext_sck(ext_sck), .wr_en(wr_en), .wr_data(wr_data), .tie(tie), .teie(teie),
      .sck_out(sck_out), .txd(txd), .tdre(tdre), .tend(tend),
      .txi_req(txi_req), .tei_req(tei_req)
   );

   int nchk = 0;
   int nfail = 0;
   bit finished = 1'b0;

   // pin monitor, sampled on the falling system clock edge
   logic mrecv [0:63];
   int   nrecv = 0, first_fall = -1, last_rise = -1;
   int   lo_cnt = 0, lo_min = 1000, lo_max = 0, cyc = 0;
   int   clr_req = 0, clr_ack = 0;
   logic prev_s = 1'b1;

   always @(negedge clk) begin : mon
      logic cur;
      cur = ext_mode ? ext_sck : sck_out;
      if (clr_req != clr_ack) begin
         clr_ack = clr_req;
         nrecv = 0; first_fall = -1; last_rise = -1;
         lo_cnt = 0; lo_min = 1000; lo_max = 0;
      end else if (rst_n) begin
         if (prev_s && !cur && first_fall < 0) first_fall = cyc;
         if (!prev_s && cur) begin
            if (nrecv < 64) mrecv[nrecv] = txd;
            nrecv++;
            last_rise = cyc;
            if (lo_cnt < lo_min) lo_min = lo_cnt;
            if (lo_cnt > lo_max) lo_max = lo_cnt;
         end
         if (!cur) lo_cnt++;
         else      lo_cnt = 0;
      end
      prev_s = cur;
      cyc++;
   end

   task automatic chk(input string tag, input int act, input int exp);
      nchk++;
      if (act != exp) begin
         nfail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic step(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic mon_clear();
      clr_req++;
      @(negedge clk);
      step(1);
   endtask

   task automatic wr(input logic [7:0] b);
      wr_en = 1'b1; wr_data = b;
      step(1);
      wr_en = 1'b0;
   endtask

   task automatic wait_tend();
      int g = 0;
      while (!tend && g < 5000) begin step(1); g++; end
      step(3);
   endtask

   // rebuilds byte k from bits seen at rising serial clock edges, LSB first
   function automatic logic [7:0] got_byte(input int k);
      logic [7:0] v;
      for (int i = 0; i < 8; i++) v[i] = mrecv[8*k + i];
      return v;
   endfunction

   function automatic int exp_span(input int nbytes, input int dv);
      return (16*nbytes - 1) * (dv + 1);
   endfunction

   task automatic run_frames(input logic [7:0] b0, input logic [7:0] b1,
                             input logic [7:0] b2, input int n, input int dv);
      logic [7:0] bs [3];
      bs[0] = b0; bs[1] = b1; bs[2] = b2;
      div = 8'(dv);
      tx_en = 1'b1;
      mon_clear();
      wr(bs[0]);
      chk("R2 empty cleared by write", int'(tdre), 0);
      chk("R2 end cleared by write", int'(tend), 0);
      chk("R8 txi low while full", int'(txi_req), 0);
      step(1);
      chk("R3 empty set on load", int'(tdre), 1);
      chk("R3 clock low on load", int'(sck_out), 0);
      chk("R3 bit0 on load", int'(txd), int'(bs[0][0]));
      chk("R8 txi follows tie", int'(txi_req), int'(tie));
      for (int k = 1; k < n; k++) begin
         int g = 0;
         while (!tdre && g < 5000) begin step(1); g++; end
         wr(bs[k]);
      end
      wait_tend();
      chk("R5 pulse count", nrecv, 8*n);
      for (int k = 0; k < n; k++)
         chk(n > 1 ? "R6 chained byte" : "R4 byte order", int'(got_byte(k)), int'(bs[k]));
      chk("R5 low phase min", lo_min, dv + 1);
      chk("R5 low phase max", lo_max, dv + 1);
      chk(n > 1 ? "R6 no gap span" : "R5 frame span", last_rise - first_fall, exp_span(n, dv));
      chk("R7 end flag", int'(tend), 1);
      chk("R7 data holds msb", int'(txd), int'(bs[n-1][7]));
      chk("R7 clock rests high", int'(sck_out), 1);
      chk("R8 tei follows teie", int'(tei_req), int'(teie));
      chk("R8 txi follows tie at end", int'(txi_req), int'(tie));
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!finished) begin
         nfail++;
         $display("FAIL watchdog all requirements actual=timeout expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
         $finish;
      end
   end

   initial begin : main
      void'($urandom(32'd20241));
      step(3);
      // R1 reset state, sampled while reset is held
      chk("R1 empty after reset", int'(tdre), 1);
      chk("R1 end after reset", int'(tend), 1);
      chk("R1 clock high after reset", int'(sck_out), 1);
      chk("R1 data high after reset", int'(txd), 1);
      rst_n = 1'b1;
      step(2);
      chk("R8 no requests when disabled", int'(txi_req | tei_req), 0);
      tie = 1'b1; teie = 1'b1;
      #1;
      chk("R8 txi with empty", int'(txi_req), 1);
      chk("R8 tei with end", int'(tei_req), 1);

      // directed frames
      run_frames(8'hA5, 8'h00, 8'h00, 1, 2);
      run_frames(8'h7E, 8'h00, 8'h00, 1, 0);
      run_frames(8'h3C, 8'h81, 8'hFF, 3, 0);
      run_frames(8'h01, 8'hFE, 8'h00, 2, 3);

      // R10 abort mid-frame, then write while disabled
      div = 8'd3;
      wr(8'h55);
      step(20);
      tx_en = 1'b0;
      step(1);
      chk("R10 data high on abort", int'(txd), 1);
      chk("R10 clock high on abort", int'(sck_out), 1);
      chk("R10 empty kept", int'(tdre), 1);
      chk("R10 end kept", int'(tend), 0);
      wr(8'h0F);
      step(20);
      chk("R10 no load while disabled", int'(tdre), 0);
      chk("R10 clock idle while disabled", int'(sck_out), 1);
      chk("R10 data idle while disabled", int'(txd), 1);
      mon_clear();
      tx_en = 1'b1;
      wait_tend();
      chk("R10 byte after enable", int'(got_byte(0)), 8'h0F);

      // R9 external clock mode
      ext_mode = 1'b1;
      ext_sck = 1'b1;
      step(2);
      mon_clear();
      wr(8'hC6);
      step(10);
      chk("R9 no load without falling edge", int'(tdre), 0);
      for (int p = 0; p < 8; p++) begin
         ext_sck = 1'b0; step(6);
         ext_sck = 1'b1; step(6);
         chk("R9 clock pin stays high", int'(sck_out), 1);
      end
      ext_sck = 1'b0;
      step(6);
      chk("R9 end after ninth fall", int'(tend), 1);
      chk("R9 bit count", nrecv, 8);
      chk("R9 byte order", int'(got_byte(0)), 8'hC6);
      chk("R9 data holds msb", int'(txd), 1);
      ext_sck = 1'b1;
      step(6);
      ext_mode = 1'b0;
      step(2);

      // constrained random frames
      for (int it = 0; it < 12; it++) begin
         int         dv, n;
         logic [7:0] r0, r1, r2;
         dv = int'($urandom % 4);
         n  = 1 + int'($urandom % 3);
         r0 = 8'($urandom); r1 = 8'($urandom); r2 = 8'($urandom);
         tie  = 1'($urandom);
         teie = 1'($urandom);
         run_frames(r0, r1, r2, n, dv);
      end

      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
   end
endmodule